// File: doc/BRIEF.md
# FPGA Configuration Phase Controller

This block sits on a simple register bus and walks an attached programmable fabric through its configuration phases: off, reset, configuration, initialization and user mode, plus an error phase for a target that reports a failure. Software enables the block, holds the configuration reset by setting a pull bit, then releases it. The block drives the active-low configuration reset line, tracks the phase from the target's status-ok, config-done and init-done indications and a burst-complete input, and reports the phase in a status register.

The status register also carries the mode-select pins, sampled every cycle. From the same sampled value the block works out the clock-to-data ratio code and the data width that software is advised to program. The control register holds the drive enable, an active-low chip enable, the reset pull, the ratio code, the data-path enable and the width select. Its fields are presented on output pins for the data path, which is a separate block.

Top module: `cfg_phase_ctrl`

## Requirements
- R1: After a synchronous active-low reset the phase is 0 (off), the control register reads 0x002 (only the chip-enable bit set), cfg_reset_n is 1 and lines_drive is 0.
- R2: A read of offset 0x0 returns the phase in bits [2:0] and, in bits [7:3], the mode-select pins as registered one cycle earlier. Bits [31:8] are 0.
- R3: Offset 0x4 is the control register: bit 0 drive enable, bit 1 active-low chip enable, bit 2 reset pull, bits [7:6] ratio code, bit 8 data-path enable, bit 9 wide width. Other bits read 0. Any read returns its data on bus_rdata one cycle after the request and holds it until the next read. Reads of other offsets return 0, and writes to them change nothing.
- R4: The block is active only when bit 0 is 1 and bit 1 is 0. When it is inactive, the phase becomes off on the next cycle and cfg_reset_n is 1.
- R5: While the block is active with the pull bit set, cfg_reset_n is 0 and the phase becomes 1 (reset) on the next cycle, whatever the phase was before.
- R6: In reset phase with the pull bit cleared and the block active, the phase becomes 2 (configuration) on the next cycle. In off phase with the pull bit clear, the phase stays off.
- R7: The configuration phase moves to 3 (initialization) only in a cycle where tgt_cfg_done and burst_done are both 1.
- R8: In the configuration phase, a cycle with tgt_status_ok and tgt_cfg_done both 0 moves the phase to 5 (unknown). The phase leaves 5 only through the pull bit or by going inactive.
- R9: The initialization phase moves to 4 (user mode) when tgt_init_done is 1. User mode is reached from no other phase.
- R10: rec_ratio is computed from the registered mode-select value m, taking m[3:0] AND 0xb. A result of 0xa gives code 3 (x8), 0x2 or 0x9 give 2 (x4), 0x1 gives 1 (x2), and every other result gives 0 (x1). rec_wide equals m[3].
- R11: lines_drive, ratio_code, data_path_en and wide_data equal control bits 0, [7:6], 8 and 9. They take a written value in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| msel_pins | input | 5 | Mode-select pins |
| tgt_status_ok | input | 1 | Target reports no error |
| tgt_cfg_done | input | 1 | Target reports configuration complete |
| tgt_init_done | input | 1 | Target reports initialization complete |
| burst_done | input | 1 | Clock burst has completed |
| cfg_reset_n | output | 1 | Active-low configuration reset line |
| lines_drive | output | 1 | Block drives the configuration lines |
| data_path_en | output | 1 | Data path enable |
| wide_data | output | 1 | Wide data width selected |
| ratio_code | output | 2 | Programmed clock-to-data ratio code |
| rec_ratio | output | 2 | Ratio code advised by the mode-select pins |
| rec_wide | output | 1 | Width advised by the mode-select pins |
| phase | output | 3 | Current phase |

## Verification
On every cycle, the assertions check the phase rules. An inactive block returns to off. The pull bit forces reset. Initialization needs both config-done and a completed burst. User mode follows only initialization, and the error phase stays put. They also check that writes to unused offsets leave the control register unchanged, and that cfg_reset_n stays high while the block is idle. Only the bench scenarios show the full sequence from reset through user mode and the error entry and its exit. They also cover the register readback with reserved bits masked, the one-cycle read latency, and the advised ratio and width for all 32 mode-select values. All of these are compared every clock against a behavioural model.

// File: rtl/cfg_phase_pkg.sv
// Package: shared types and field positions for the configuration phase controller.
// Assumes the control word fits in the low CTRL_WORD_W bits of the bus word.
package cfg_phase_pkg;

    typedef enum logic [2:0] {
        PH_OFF     = 3'd0,
        PH_RESET   = 3'd1,
        PH_CONFIG  = 3'd2,
        PH_INIT    = 3'd3,
        PH_USER    = 3'd4,
        PH_UNKNOWN = 3'd5
    } phase_t;

    localparam int PHASE_W     = 3;
    localparam int RATIO_W     = 2;
    localparam int CTRL_WORD_W = 10;

    localparam int BIT_EN    = 0;
    localparam int BIT_NCE   = 1;
    localparam int BIT_PULL  = 2;
    localparam int BIT_RATIO = 6;
    localparam int BIT_DPATH = 8;
    localparam int BIT_WIDE  = 9;

    typedef struct packed {
        logic               wide;
        logic               dpath;
        logic [RATIO_W-1:0] ratio;
        logic               pull;
        logic               nce;
        logic               en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{wide: 1'b0, dpath: 1'b0, ratio: '0,
                                     pull: 1'b0, nce: 1'b1, en: 1'b0};

    // Unpack a bus word into control fields; reserved bits are dropped.
    function automatic ctrl_t word_to_ctrl(input logic [CTRL_WORD_W-1:0] w);
        ctrl_t c;
        c.en    = w[BIT_EN];
        c.nce   = w[BIT_NCE];
        c.pull  = w[BIT_PULL];
        c.ratio = w[BIT_RATIO +: RATIO_W];
        c.dpath = w[BIT_DPATH];
        c.wide  = w[BIT_WIDE];
        return c;
    endfunction

    // Pack control fields into their bus positions; reserved bits are zero.
    function automatic logic [CTRL_WORD_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [CTRL_WORD_W-1:0] w;
        w = '0;
        w[BIT_EN]                = c.en;
        w[BIT_NCE]               = c.nce;
        w[BIT_PULL]              = c.pull;
        w[BIT_RATIO +: RATIO_W]  = c.ratio;
        w[BIT_DPATH]             = c.dpath;
        w[BIT_WIDE]              = c.wide;
        return w;
    endfunction

endpackage

// File: rtl/cfg_mode_advisor.sv
// Module: derives the advised ratio code and data width from the sampled
// mode-select value. Purely combinational. Assumes MSEL_W >= 4.
module cfg_mode_advisor
    import cfg_phase_pkg::*;
#(
    parameter int MSEL_W = 5
) (
    input  logic [MSEL_W-1:0]  msel,
    output logic [RATIO_W-1:0] rec_ratio,
    output logic               rec_wide
);

    localparam logic [3:0] RATIO_MASK = 4'hb;

    logic [3:0] masked;

    // Map the masked mode-select value onto a ratio code.
    always_comb begin
        masked = msel[3:0] & RATIO_MASK;
        case (masked)
            4'ha:       rec_ratio = 2'd3;
            4'h2, 4'h9: rec_ratio = 2'd2;
            4'h1:       rec_ratio = 2'd1;
            default:    rec_ratio = 2'd0;
        endcase
        rec_wide = msel[3];
    end

endmodule

// File: rtl/cfg_phase_regs.sv
// Module: register bank. Holds the control register, samples the mode-select
// pins and returns registered read data one cycle after a read request.
// Assumes byte offsets on the bus; unused offsets read zero and ignore writes.
module cfg_phase_regs
    import cfg_phase_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int MSEL_W      = 5,
    parameter int STATUS_OFFS = 0,
    parameter int CTRL_OFFS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  phase_t            phase,
    input  logic [MSEL_W-1:0] msel_pins,
    output ctrl_t             ctrl_q,
    output logic [MSEL_W-1:0] msel_q,
    output logic [DATA_W-1:0] rdata
);

    localparam int MSEL_LSB = PHASE_W;
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_OFFS);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(CTRL_OFFS);

    logic              wr_ctrl;
    logic              rd_req;
    logic [DATA_W-1:0] rd_word;

    assign wr_ctrl = sel && wr && (addr == A_CTRL);
    assign rd_req  = sel && !wr;

    // Select the read word for the addressed register.
    always_comb begin
        rd_word = '0;
        if (addr == A_STATUS) begin
            rd_word[PHASE_W-1:0]         = phase;
            rd_word[MSEL_LSB +: MSEL_W]  = msel_q;
        end else if (addr == A_CTRL) begin
            rd_word[CTRL_WORD_W-1:0] = ctrl_to_word(ctrl_q);
        end
    end

    // Control register update on a write to its offset.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RESET;
        else if (wr_ctrl) ctrl_q <= word_to_ctrl(wdata[CTRL_WORD_W-1:0]);
    end

    // Sample the mode-select pins every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) msel_q <= '0;
        else        msel_q <= msel_pins;
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_req) rdata <= rd_word;
    end

    a_r3_other_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr != A_CTRL) |=> $stable(ctrl_q));

    a_r2_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && addr == A_STATUS) |=> (rdata[DATA_W-1:MSEL_LSB+MSEL_W] == '0));

endmodule

// File: rtl/cfg_phase_fsm.sv
// Module: configuration phase state machine. Advances through reset,
// configuration, initialization and user mode from the control bits and the
// target's indications. Assumes all inputs are synchronous to clk.
module cfg_phase_fsm
    import cfg_phase_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   active,
    input  logic   pull,
    input  logic   status_ok,
    input  logic   cfg_done,
    input  logic   burst_done,
    input  logic   init_done,
    output phase_t phase_q
);

    phase_t phase_n;

    // Next-phase decision; idle and pull take priority over progress.
    always_comb begin
        phase_n = phase_q;
        if (!active) begin
            phase_n = PH_OFF;
        end else if (pull) begin
            phase_n = PH_RESET;
        end else begin
            case (phase_q)
                PH_RESET:  phase_n = PH_CONFIG;
                PH_CONFIG: begin
                    if (cfg_done && burst_done)    phase_n = PH_INIT;
                    else if (!status_ok && !cfg_done) phase_n = PH_UNKNOWN;
                end
                PH_INIT:   if (init_done) phase_n = PH_USER;
                default:   phase_n = phase_q;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_OFF;
        else        phase_q <= phase_n;
    end

    a_r4_off_when_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (phase_q == PH_OFF));

    a_r5_pull_enters_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (active && pull) |=> (phase_q == PH_RESET));

    a_r7_init_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CONFIG && !(cfg_done && burst_done)) |=> (phase_q != PH_INIT));

    a_r9_user_only_from_init: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_USER && phase_q != PH_INIT) |=> (phase_q != PH_USER));

    a_r8_unknown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_UNKNOWN && active && !pull) |=> (phase_q == PH_UNKNOWN));

endmodule

// File: rtl/cfg_phase_ctrl.sv
// Module: top of the configuration phase controller. Joins the register bank,
// the phase state machine and the mode advisor, and drives the reset line.
// Assumes a single clock domain and synchronous target indications.
module cfg_phase_ctrl
    import cfg_phase_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int MSEL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [MSEL_W-1:0] msel_pins,
    input  logic              tgt_status_ok,
    input  logic              tgt_cfg_done,
    input  logic              tgt_init_done,
    input  logic              burst_done,
    output logic              cfg_reset_n,
    output logic              lines_drive,
    output logic              data_path_en,
    output logic              wide_data,
    output logic [1:0]        ratio_code,
    output logic [1:0]        rec_ratio,
    output logic              rec_wide,
    output logic [2:0]        phase
);

    ctrl_t             ctrl_q;
    logic [MSEL_W-1:0] msel_q;
    phase_t            phase_q;
    logic              active;

    cfg_phase_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MSEL_W(MSEL_W),
        .STATUS_OFFS(0), .CTRL_OFFS(4)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr),
        .addr(bus_addr), .wdata(bus_wdata), .phase(phase_q),
        .msel_pins(msel_pins), .ctrl_q(ctrl_q), .msel_q(msel_q),
        .rdata(bus_rdata)
    );

    cfg_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active), .pull(ctrl_q.pull),
        .status_ok(tgt_status_ok), .cfg_done(tgt_cfg_done),
        .burst_done(burst_done), .init_done(tgt_init_done),
        .phase_q(phase_q)
    );

    cfg_mode_advisor #(.MSEL_W(MSEL_W)) u_adv (
        .msel(msel_q), .rec_ratio(rec_ratio), .rec_wide(rec_wide)
    );

    // Drive the configuration lines and expose the control fields.
    always_comb begin
        active       = ctrl_q.en && !ctrl_q.nce;
        cfg_reset_n  = !(active && ctrl_q.pull);
        lines_drive  = ctrl_q.en;
        data_path_en = ctrl_q.dpath;
        wide_data    = ctrl_q.wide;
        ratio_code   = ctrl_q.ratio;
        phase        = phase_q;
    end

    a_r4_reset_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_OFF && !lines_drive) |-> cfg_reset_n);

endmodule

// File: tb/test_cfg_phase_ctrl.sv
module test_cfg_phase_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  msel_pins = 5'h13;
    logic        tgt_status_ok = 1'b1, tgt_cfg_done = 1'b0, tgt_init_done = 1'b0;
    logic        burst_done = 1'b0;
    logic        cfg_reset_n, lines_drive, data_path_en, wide_data, rec_wide;
    logic [1:0]  ratio_code, rec_ratio;
    logic [2:0]  phase;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cfg_phase_ctrl i_cfg_phase_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .msel_pins(msel_pins), .tgt_status_ok(tgt_status_ok),
        .tgt_cfg_done(tgt_cfg_done), .tgt_init_done(tgt_init_done),
        .burst_done(burst_done), .cfg_reset_n(cfg_reset_n),
        .lines_drive(lines_drive), .data_path_en(data_path_en),
        .wide_data(wide_data), .ratio_code(ratio_code),
        .rec_ratio(rec_ratio), .rec_wide(rec_wide), .phase(phase)
    );

    // Behavioural reference state.
    int m_ctrl, m_phase, m_msel, m_rdata;

    function automatic int advise(input int m);
        int k = m & 'hb;
        if (k == 'ha) return 3;
        if (k == 'h2 || k == 'h9) return 2;
        if (k == 'h1) return 1;
        return 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model step at each clock edge.
    always @(posedge clk) begin
        int act, nxt, rd;
        if (!rst_n) begin
            m_ctrl = 2; m_phase = 0; m_msel = 0; m_rdata = 0;
        end else begin
            act = ((m_ctrl & 1) != 0 && (m_ctrl & 2) == 0) ? 1 : 0;
            nxt = m_phase;
            if (act == 0) nxt = 0;
            else if ((m_ctrl & 4) != 0) nxt = 1;
            else if (m_phase == 1) nxt = 2;
            else if (m_phase == 2) begin
                if (tgt_cfg_done && burst_done) nxt = 3;
                else if (!tgt_status_ok && !tgt_cfg_done) nxt = 5;
            end else if (m_phase == 3 && tgt_init_done) nxt = 4;
            rd = m_rdata;
            if (bus_sel && !bus_wr)
                rd = (bus_addr == 0) ? ((m_msel << 3) | m_phase) :
                     (bus_addr == 4) ? m_ctrl : 0;
            if (bus_sel && bus_wr && bus_addr == 4) m_ctrl = bus_wdata & 'h3c7;
            m_msel = int'(msel_pins);
            m_phase = nxt;
            m_rdata = rd;
        end
    end

    // Compare every output against the model shortly after each edge.
    always @(posedge clk) begin
        int act;
        #2;
        if (!done) begin
            act = ((m_ctrl & 1) != 0 && (m_ctrl & 2) == 0) ? 1 : 0;
            check("R2 R3 rdata", int'(bus_rdata), m_rdata);
            check("R4 R5 R6 R7 R8 R9 phase", int'(phase), m_phase);
            check("R4 R5 cfg_reset_n", int'(cfg_reset_n), (act == 1 && (m_ctrl & 4) != 0) ? 0 : 1);
            check("R11 controls", {28'd0, wide_data, data_path_en, ratio_code} ,
                  (((m_ctrl >> 9) & 1) << 3) | (((m_ctrl >> 8) & 1) << 2) | ((m_ctrl >> 6) & 3));
            check("R11 lines_drive", int'(lines_drive), m_ctrl & 1);
            check("R10 advice", {29'd0, rec_wide, rec_ratio}, (((m_msel >> 3) & 1) << 2) | advise(m_msel));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input int a, input int d);
        bus_sel = 1; bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input int a, output int d);
        bus_sel = 1; bus_wr = 0; bus_addr = 4'(a);
        @(negedge clk);
        bus_sel = 0;
        d = int'(bus_rdata);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        int v;
        step(4);
        rst_n = 1;
        step(1);
        // R1 reset state
        check("R1 phase", int'(phase), 0);
        check("R1 cfg_reset_n", int'(cfg_reset_n), 1);
        check("R1 lines_drive", int'(lines_drive), 0);
        bus_read(4, v); check("R1 ctrl reset value", v, 'h002);
        bus_read(0, v); check("R2 status off msel 0x13", v, 'h98);

        bus_write(4, 'h001); step(1);
        check("R6 off stays off without pull", int'(phase), 0);
        bus_write(4, 'h005);
        check("R5 reset line low", int'(cfg_reset_n), 0);
        step(1); check("R5 reset phase", int'(phase), 1);
        bus_read(0, v); check("R2 status reset phase", v, 'h99);
        bus_write(4, 'h001);
        check("R6 reset line released", int'(cfg_reset_n), 1);
        step(1); check("R6 configuration phase", int'(phase), 2);

        tgt_cfg_done = 1; step(3);
        check("R7 no burst keeps config", int'(phase), 2);
        burst_done = 1; step(1);
        check("R7 init phase", int'(phase), 3);
        burst_done = 0; tgt_cfg_done = 0; step(2);
        check("R9 init holds without init_done", int'(phase), 3);
        tgt_init_done = 1; step(1);
        check("R9 user mode", int'(phase), 4);
        tgt_init_done = 0;
        bus_write(4, 'h000); step(1);
        check("R4 disabled goes off", int'(phase), 0);
        check("R4 lines released", int'(lines_drive), 0);

        bus_write(4, 'h005); step(1);
        bus_write(4, 'h001); step(1);
        check("R6 config again", int'(phase), 2);
        tgt_status_ok = 0; step(1);
        check("R8 error phase", int'(phase), 5);
        tgt_status_ok = 1; tgt_cfg_done = 1; burst_done = 1; tgt_init_done = 1; step(2);
        check("R8 error phase sticky", int'(phase), 5);
        tgt_cfg_done = 0; burst_done = 0; tgt_init_done = 0;
        bus_write(4, 'h005); step(1);
        check("R8 pull leaves error", int'(phase), 1);

        bus_write(4, 'h007);
        check("R4 chip enable high releases reset line", int'(cfg_reset_n), 1);
        step(1); check("R4 chip enable high gives off", int'(phase), 0);

        bus_write(4, 'hffffffff);
        bus_read(4, v); check("R3 reserved bits read zero", v, 'h3c7);
        check("R11 ratio all ones", int'(ratio_code), 3);
        check("R11 wide and data path", {30'd0, wide_data, data_path_en}, 3);
        bus_write(4, 'h141);
        check("R11 ratio x2", int'(ratio_code), 1);
        check("R11 narrow width", int'(wide_data), 0);
        bus_read(4, v); check("R3 ctrl readback", v, 'h141);
        bus_read(8, v); check("R3 unused offset reads zero", v, 0);
        bus_write(8, 'h3c6);
        bus_read(4, v); check("R3 write to unused offset ignored", v, 'h141);
        step(1); check("R6 active off without pull stays off", int'(phase), 0);

        for (int m = 0; m < 32; m++) begin
            msel_pins = 5'(m); step(1);
            check("R10 advised ratio", int'(rec_ratio), advise(m));
            check("R10 advised width", int'(rec_wide), (m >> 3) & 1);
        end
        bus_read(0, v); check("R2 status msel 0x1f", v, 'hf8);

        step(2);
        finish_run();
    end

endmodule